// File: doc/BRIEF.md
# Received-frame queue screener with flexible compares

This block assigns each received Ethernet frame to a receive queue. It looks at the frame's byte stream as the bytes arrive. A small set of screening rules runs against that stream. Each rule can check the frame's EtherType against one entry of an EtherType table. It can also run up to three masked 16-bit compares, named slots A, B and C. Each slot points into a shared table of compare entries. A compare entry gives the byte offset, the point in the frame that offset counts from, the expected value and the mask.

Software loads the rule words, the EtherType table and the compare entries through a simple write port. A rule hits when at least one of its enabled tests matches and none of its enabled tests fails. Among the rules that hit, the lowest-numbered one supplies the queue number and the drop flag. A frame that hits no rule goes to queue 0 and is kept. The result appears as a single-cycle strobe shortly after the frame's last byte.

Top module: `rxq_screener`

## Requirements
- R1: After a synchronous active-low reset, res_valid, res_queue and res_drop are 0. Every rule word, EtherType entry and compare entry is 0, so no rule is enabled and every frame ends in queue 0.
- R2: The cycle in which the frame's last byte is accepted (rx_valid and rx_eof high) is edge E. res_valid is high for exactly one cycle, the one that follows edge E+1. Outside that pulse res_queue and res_drop are 0.
- R3: Rule word layout. The queue number is in bits [3:0]. The EtherType table index is in [11:9] and the EtherType enable is bit 12. Slot A uses index [17:13] with enable bit 18. Slot B uses index [23:19] with enable bit 24. Slot C uses index [29:25] with enable bit 30. Drop-on-hit is bit 31. Bits [8:4] have no effect.
- R4: The EtherType is formed from frame bytes 12 (high) and 13 (low). It matches when it equals bits [15:0] of the selected EtherType table entry.
- R5: Compare entry word 0 holds the mask in [15:0] and the value in [31:16]. Word 1 holds the byte offset in [6:0], the base select in [8:7] and a full-compare flag in bit 9. A slot matches when (field AND mask) equals (value AND mask).
- R6: The 16-bit field is read big-endian from frame bytes base+offset (high byte) and base+offset+1 (low byte). Base select 0 is byte 0, 1 is byte 14, 2 is byte 14 (start of an untagged IP header), and 3 is byte 42 (just after a UDP header).
- R7: When the full-compare flag is set, the mask is taken as 16'hFFFF whatever word 0 holds.
- R8: A rule hits only if at least one of its enabled tests matches and none mismatches. A rule with no test enabled never hits.
- R9: A slot index at or above the number of compare entries counts as a mismatch. So does an enabled test whose field bytes were not all received before the frame ended.
- R10: When several rules hit, the lowest-numbered one sets res_queue. When no rule hits, res_queue is 0 and res_drop is 0.
- R11: res_drop equals bit 31 of the winning rule.
- R12: A write with cfg_we high stores cfg_wdata into the table chosen by cfg_sel at entry cfg_idx. The cfg_sel codes are 0 for rule words, 1 for EtherType entries, 2 for compare word 0 and 3 for compare word 1. A write whose cfg_idx is beyond the chosen table changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Table select: 0 rule, 1 EtherType, 2 compare word 0, 3 compare word 1 |
| cfg_idx | input | 5 | Entry within the selected table |
| cfg_wdata | input | 32 | Write data |
| rx_valid | input | 1 | A frame byte is present this cycle |
| rx_sof | input | 1 | This byte is byte 0 of a frame |
| rx_eof | input | 1 | This byte is the last byte of the frame |
| rx_data | input | 8 | Frame byte |
| res_valid | output | 1 | One-cycle result strobe |
| res_queue | output | 4 | Selected queue |
| res_drop | output | 1 | Drop the frame |

## Verification
Each rule keeps captured field bytes and per-slot received flags. If a capture lands on the wrong byte position or keeps stale data from the previous frame, the fault shows up at res_queue in the same frame's result, two cycles after the last byte. That fault appears as a missed or a false hit. A fault in the priority pick or the drop path shows only when two rules hit together or when the winning rule carries the drop bit. For that reason the directed frames deliberately cause overlapping hits and short frames.

// File: rtl/scr_pkg.sv
// Package: shared field positions and encodings for the queue screener.
// Assumes untagged frames, so the IP header begins right after the EtherType.
package scr_pkg;
    localparam int POSW        = 8;   // byte position width; covers 42+127+1
    localparam int QW          = 4;   // queue number width
    localparam int SLOTS       = 3;   // compare slots per rule
    localparam int Q_LSB       = 0;
    localparam int ET_IDX_LSB  = 9;
    localparam int ET_IDX_W    = 3;
    localparam int ET_EN_BIT   = 12;
    localparam int SLOT_LSB    = 13;
    localparam int SLOT_STRIDE = 6;
    localparam int SLOT_IDX_W  = 5;
    localparam int DROP_BIT    = 31;
    localparam int OFS_W       = 7;
    localparam int BASE_LSB    = 7;
    localparam int FULLCMP_BIT = 9;
    localparam int ET_POS      = 12;

    typedef enum logic [1:0] {
        TBL_RULE = 2'd0,
        TBL_ETYPE = 2'd1,
        TBL_CMPW0 = 2'd2,
        TBL_CMPW1 = 2'd3
    } tbl_sel_e;

    // First byte position of each offset base.
    function automatic logic [POSW-1:0] base_start(input logic [1:0] b);
        case (b)
            2'd0:    base_start = POSW'(0);
            2'd1:    base_start = POSW'(14);
            2'd2:    base_start = POSW'(14);
            default: base_start = POSW'(42);
        endcase
    endfunction
endpackage

// File: rtl/scr_cfg_regs.sv
// Module: holds the rule words, the EtherType table and the compare entries.
// Assumes the tables are written only between frames; writes outside a table are dropped.
module scr_cfg_regs #(
    parameter int NUM_RULE  = 4,
    parameter int NUM_ETYPE = 8,
    parameter int NUM_CMP   = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [1:0]                       sel,
    input  logic [4:0]                       idx,
    input  logic [31:0]                      wdata,
    output logic [NUM_RULE-1:0][31:0]        rule_q,
    output logic [NUM_ETYPE-1:0][15:0]       etype_q,
    output logic [NUM_CMP-1:0][31:0]         cmp0_q,
    output logic [NUM_CMP-1:0][31:0]         cmp1_q
);
    import scr_pkg::*;

    // Table storage: clear on reset, write the addressed entry when in range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rule_q  <= '0;
            etype_q <= '0;
            cmp0_q  <= '0;
            cmp1_q  <= '0;
        end else if (we) begin
            for (int k = 0; k < NUM_RULE; k++)
                if (sel == TBL_RULE && int'(idx) == k) rule_q[k] <= wdata;
            for (int k = 0; k < NUM_ETYPE; k++)
                if (sel == TBL_ETYPE && int'(idx) == k) etype_q[k] <= wdata[15:0];
            for (int k = 0; k < NUM_CMP; k++) begin
                if (sel == TBL_CMPW0 && int'(idx) == k) cmp0_q[k] <= wdata;
                if (sel == TBL_CMPW1 && int'(idx) == k) cmp1_q[k] <= wdata;
            end
        end
    end

    // R12: an out-of-range rule write must leave every rule word unchanged.
    assert_rule_write_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == TBL_RULE && int'(idx) >= NUM_RULE) |=> $stable(rule_q));
endmodule

// File: rtl/scr_field_grab.sv
// Module: captures a big-endian 16-bit field at a programmable byte position.
// Assumes the position is stable during a frame; flags clear at each frame start.
module scr_field_grab (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_en,
    input  logic                    sof,
    input  logic [scr_pkg::POSW-1:0] cur_pos,
    input  logic [7:0]              data,
    input  logic [scr_pkg::POSW-1:0] target,
    output logic [15:0]             field,
    output logic                    got
);
    import scr_pkg::*;

    logic            have_hi;
    logic            have_hi_eff;
    logic [POSW:0]   tgt_next;

    assign have_hi_eff = have_hi && !sof;
    assign tgt_next    = {1'b0, target} + (POSW+1)'(1);

    // Capture high byte at target, low byte right after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field   <= '0;
            have_hi <= 1'b0;
            got     <= 1'b0;
        end else if (byte_en) begin
            if (cur_pos == target) begin
                field[15:8] <= data;
                have_hi     <= 1'b1;
            end else if (sof) begin
                have_hi <= 1'b0;
            end
            if (have_hi_eff && {1'b0, cur_pos} == tgt_next) begin
                field[7:0] <= data;
                got        <= 1'b1;
            end else if (sof) begin
                got <= 1'b0;
            end
        end
    end

    // R6: a field completes only on an accepted frame byte.
    assert_got_on_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(got) |-> $past(byte_en));
endmodule

// File: rtl/scr_rule_eval.sv
// Module: evaluates one screening rule from captured fields and the tables.
// Assumes captures reflect the frame just ended; purely combinational apart from checks.
module scr_rule_eval #(
    parameter int NUM_ETYPE = 8,
    parameter int NUM_CMP   = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [31:0]                           rule,
    input  logic [NUM_ETYPE-1:0][15:0]            etype_tab,
    input  logic [NUM_CMP-1:0][31:0]              cmp0_tab,
    input  logic [NUM_CMP-1:0][31:0]              cmp1_tab,
    input  logic [15:0]                           et_field,
    input  logic                                  et_got,
    input  logic [scr_pkg::SLOTS-1:0][15:0]       slot_field,
    input  logic [scr_pkg::SLOTS-1:0]             slot_got,
    output logic [scr_pkg::SLOTS-1:0][scr_pkg::POSW-1:0] slot_target,
    output logic                                  hit
);
    import scr_pkg::*;

    logic [SLOTS-1:0] slot_en;
    logic [SLOTS-1:0] slot_ok;
    logic             et_ok;
    logic             any_match;
    logic             any_miss;
    logic             unused_bits;

    assign unused_bits = ^{rule[8:4], cmp1_tab};

    // EtherType test: table lookup by index, big-endian compare.
    always_comb begin
        logic [ET_IDX_W-1:0] ei;
        ei    = rule[ET_IDX_LSB +: ET_IDX_W];
        et_ok = 1'b0;
        for (int k = 0; k < NUM_ETYPE; k++)
            if (int'(ei) == k) et_ok = et_got && (et_field == etype_tab[k]);
    end

    // Slot tests: indirect entry select, target position, masked compare.
    always_comb begin
        for (int j = 0; j < SLOTS; j++) begin
            logic [SLOT_IDX_W-1:0] si;
            logic [31:0] w0, w1;
            logic [15:0] msk;
            logic        in_rng;
            si     = rule[SLOT_LSB + j*SLOT_STRIDE +: SLOT_IDX_W];
            slot_en[j] = rule[SLOT_LSB + j*SLOT_STRIDE + SLOT_IDX_W];
            w0     = '0;
            w1     = '0;
            in_rng = 1'b0;
            for (int k = 0; k < NUM_CMP; k++)
                if (int'(si) == k) begin
                    w0     = cmp0_tab[k];
                    w1     = cmp1_tab[k];
                    in_rng = 1'b1;
                end
            msk = w1[FULLCMP_BIT] ? 16'hFFFF : w0[15:0];
            slot_target[j] = base_start(w1[BASE_LSB +: 2]) + POSW'(w1[OFS_W-1:0]);
            slot_ok[j] = in_rng && slot_got[j] &&
                         ((slot_field[j] & msk) == (w0[31:16] & msk));
        end
    end

    // Hit rule: some enabled test matched, none of them failed.
    always_comb begin
        any_match = rule[ET_EN_BIT] && et_ok;
        any_miss  = rule[ET_EN_BIT] && !et_ok;
        for (int j = 0; j < SLOTS; j++) begin
            any_match = any_match || (slot_en[j] && slot_ok[j]);
            any_miss  = any_miss  || (slot_en[j] && !slot_ok[j]);
        end
        hit = any_match && !any_miss;
    end

    // R9: a rule can only hit if every enabled slot saw both of its bytes.
    for (genvar j = 0; j < SLOTS; j++) begin : g_chk
        assert_slot_bytes_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && slot_en[j]) |-> slot_got[j]);
    end
    // R4: an enabled EtherType test that hits needs the captured EtherType.
    assert_etype_bytes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && rule[ET_EN_BIT]) |-> et_got);
endmodule

// File: rtl/rxq_screener.sv
// Module: top of the queue screener. Tracks byte position, captures fields per rule,
// picks the lowest hitting rule and emits a one-cycle result two edges after the last byte.
// Assumes configuration is static while a frame is in flight.
module rxq_screener #(
    parameter int NUM_RULE  = 4,
    parameter int NUM_ETYPE = 8,
    parameter int NUM_CMP   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [4:0]  cfg_idx,
    input  logic [31:0] cfg_wdata,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic [7:0]  rx_data,
    output logic        res_valid,
    output logic [3:0]  res_queue,
    output logic        res_drop
);
    import scr_pkg::*;

    localparam logic [POSW-1:0] POS_MAX = '1;

    logic [NUM_RULE-1:0][31:0]            rule_q;
    logic [NUM_ETYPE-1:0][15:0]           etype_q;
    logic [NUM_CMP-1:0][31:0]             cmp0_q;
    logic [NUM_CMP-1:0][31:0]             cmp1_q;
    logic [POSW-1:0]                      pos_q;
    logic [POSW-1:0]                      cur_pos;
    logic [15:0]                          et_field;
    logic                                 et_got;
    logic [NUM_RULE-1:0][SLOTS-1:0][15:0] fld;
    logic [NUM_RULE-1:0][SLOTS-1:0]       fgot;
    logic [NUM_RULE-1:0][SLOTS-1:0][POSW-1:0] tgt;
    logic [NUM_RULE-1:0]                  hit;
    logic [NUM_RULE-1:0]                  win;
    logic [QW-1:0]                        win_queue;
    logic                                 win_drop;
    logic                                 pend;

    scr_cfg_regs #(.NUM_RULE(NUM_RULE), .NUM_ETYPE(NUM_ETYPE), .NUM_CMP(NUM_CMP)) i_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .idx(cfg_idx),
        .wdata(cfg_wdata), .rule_q(rule_q), .etype_q(etype_q),
        .cmp0_q(cmp0_q), .cmp1_q(cmp1_q)
    );

    assign cur_pos = rx_sof ? '0 : pos_q;

    // Byte position counter, restarted by the frame start, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (rx_valid)
            pos_q <= (cur_pos == POS_MAX) ? POS_MAX : cur_pos + POSW'(1);
    end

    scr_field_grab i_et_grab (
        .clk(clk), .rst_n(rst_n), .byte_en(rx_valid), .sof(rx_sof), .cur_pos(cur_pos),
        .data(rx_data), .target(POSW'(ET_POS)), .field(et_field), .got(et_got)
    );

    for (genvar i = 0; i < NUM_RULE; i++) begin : g_rule
        for (genvar j = 0; j < SLOTS; j++) begin : g_slot
            scr_field_grab i_grab (
                .clk(clk), .rst_n(rst_n), .byte_en(rx_valid), .sof(rx_sof),
                .cur_pos(cur_pos), .data(rx_data), .target(tgt[i][j]),
                .field(fld[i][j]), .got(fgot[i][j])
            );
        end
        scr_rule_eval #(.NUM_ETYPE(NUM_ETYPE), .NUM_CMP(NUM_CMP)) i_eval (
            .clk(clk), .rst_n(rst_n), .rule(rule_q[i]), .etype_tab(etype_q),
            .cmp0_tab(cmp0_q), .cmp1_tab(cmp1_q), .et_field(et_field), .et_got(et_got),
            .slot_field(fld[i]), .slot_got(fgot[i]), .slot_target(tgt[i]), .hit(hit[i])
        );
    end

    // Priority pick: lowest-numbered hitting rule wins.
    always_comb begin
        logic taken;
        taken     = 1'b0;
        win       = '0;
        win_queue = '0;
        win_drop  = 1'b0;
        for (int i = 0; i < NUM_RULE; i++) begin
            if (hit[i] && !taken) begin
                win[i]    = 1'b1;
                win_queue = rule_q[i][Q_LSB +: QW];
                win_drop  = rule_q[i][DROP_BIT];
                taken     = 1'b1;
            end
        end
    end

    // Result stage: note the last byte, then register the pick one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            res_valid <= 1'b0;
            res_queue <= '0;
            res_drop  <= 1'b0;
        end else begin
            pend      <= rx_valid && rx_eof;
            res_valid <= pend;
            res_queue <= pend ? win_queue : '0;
            res_drop  <= pend && win_drop;
        end
    end

    // R10: at most one rule is picked.
    assert_single_winner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win));
    // R2: the strobe follows the last byte by two edges.
    assert_result_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(rx_valid && rx_eof, 2));
    // R2: outputs are quiet outside the strobe.
    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_queue == '0 && !res_drop));
    // R11: a drop comes only with a hit from a rule.
    assert_drop_needs_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && win_drop) |-> (hit != '0));
endmodule

// File: tb/test_rxq_screener.sv
module test_rxq_screener;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [4:0]  cfg_idx;
    logic [31:0] cfg_wdata;
    logic        rx_valid, rx_sof, rx_eof;
    logic [7:0]  rx_data;
    logic        res_valid;
    logic [3:0]  res_queue;
    logic        res_drop;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [7:0] frm [0:63];

    always #10 clk = ~clk;

    rxq_screener i_rxq_screener (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_data(rx_data), .res_valid(res_valid), .res_queue(res_queue), .res_drop(res_drop)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [4:0] i, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_idx = i; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fill();
        for (int i = 0; i < 64; i++) frm[i] = 8'(i) ^ 8'h33;
    endtask

    // Send len bytes, check R2 timing and the expected queue and drop.
    task automatic run_frame(input int len, input logic [3:0] eq, input logic ed, input string req);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = frm[i];
            rx_sof = (i == 0); rx_eof = (i == len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        check("R2 no early strobe", {31'd0, res_valid}, 32'd0);
        @(negedge clk);
        check("R2 strobe", {31'd0, res_valid}, 32'd1);
        check({req, " queue"}, {28'd0, res_queue}, {28'd0, eq});
        check({req, " drop"}, {31'd0, res_drop}, {31'd0, ed});
        @(negedge clk);
        check("R2 single pulse", {30'd0, res_valid, res_drop}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1 reset outputs", {26'd0, res_valid, res_queue, res_drop}, 32'd0);
        fill();
        run_frame(60, 4'd0, 1'b0, "R1 empty tables");
    endtask

    task automatic t_etype();
        wr(2'd1, 5'd3, 32'h0000_88F7);
        wr(2'd0, 5'd0, 32'h0000_1605);
        fill(); frm[12] = 8'h88; frm[13] = 8'hF7;
        run_frame(60, 4'd5, 1'b0, "R4 ethertype hit");
        frm[13] = 8'hF6;
        run_frame(60, 4'd0, 1'b0, "R8 ethertype miss");
        wr(2'd0, 5'd0, 32'h0000_17F5);
        frm[13] = 8'hF7;
        run_frame(60, 4'd5, 1'b0, "R3 bits 8:4 ignored");
        wr(2'd0, 5'd0, 32'h0);
    endtask

    task automatic t_compare();
        wr(2'd2, 5'd2, 32'h1234_FF00);
        wr(2'd3, 5'd2, 32'h0000_0084);
        wr(2'd0, 5'd1, 32'h0004_4007);
        fill(); frm[18] = 8'h12; frm[19] = 8'h99;
        run_frame(60, 4'd7, 1'b0, "R5 masked match");
        frm[18] = 8'h13;
        run_frame(60, 4'd0, 1'b0, "R5 masked miss");
        wr(2'd3, 5'd2, 32'h0000_0284);
        frm[18] = 8'h12;
        run_frame(60, 4'd0, 1'b0, "R7 full compare miss");
        frm[19] = 8'h34;
        run_frame(60, 4'd7, 1'b0, "R7 full compare hit");
        wr(2'd3, 5'd2, 32'h0000_0214);
        fill(); frm[20] = 8'h12; frm[21] = 8'h34;
        run_frame(60, 4'd7, 1'b0, "R6 base 0 offset 20");
        wr(2'd0, 5'd1, 32'h0);
    endtask

    task automatic t_tail();
        wr(2'd2, 5'd5, 32'hABCD_FFFF);
        wr(2'd3, 5'd5, 32'h0000_0180);
        wr(2'd0, 5'd2, 32'h8128_0003);
        fill(); frm[42] = 8'hAB; frm[43] = 8'hCD;
        run_frame(60, 4'd3, 1'b1, "R11 base 3 drop");
        run_frame(43, 4'd0, 1'b0, "R9 short frame");
    endtask

    task automatic t_priority();
        wr(2'd0, 5'd3, 32'h0000_1609);
        fill(); frm[12] = 8'h88; frm[13] = 8'hF7; frm[42] = 8'hAB; frm[43] = 8'hCD;
        run_frame(60, 4'd3, 1'b1, "R10 lowest rule wins");
        frm[42] = 8'h00;
        run_frame(60, 4'd9, 1'b0, "R10 next rule");
        wr(2'd0, 5'd0, 32'h4A00_160C);
        run_frame(60, 4'd9, 1'b0, "R8 one test fails");
        frm[42] = 8'hAB;
        run_frame(60, 4'd12, 1'b0, "R8 both tests pass");
    endtask

    task automatic t_range();
        wr(2'd0, 5'd2, 32'h0);
        wr(2'd0, 5'd3, 32'h0);
        wr(2'd0, 5'd0, 32'h0005_3601);
        fill(); frm[12] = 8'h88; frm[13] = 8'hF7;
        run_frame(60, 4'd0, 1'b0, "R9 slot index out of range");
        wr(2'd0, 5'd0, 32'h0);
        wr(2'd0, 5'd4, 32'h0000_1605);
        run_frame(60, 4'd0, 1'b0, "R12 out-of-range write dropped");
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_idx = '0; cfg_wdata = '0;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_etype();
        t_compare();
        t_tail();
        t_priority();
        t_range();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule